// File: doc/BRIEF.md
# Serial NOR Program/Erase Sequencer

This block accepts one program or erase request at a time from a host and turns it into a series of serial NOR transactions on a byte-level SPI master. A request carries a start offset, a byte length and a direction flag. For programs, the block pulls payload bytes from the host one at a time. The block divides the request into chunks. Before each chunk it may rewrite the device's bank-select register. It then sends a write-enable in its own frame, followed by the program or erase command with a three-byte address. After the command it polls the device's status until the device reports ready.

The SPI master is driven one byte at a time. `xf_cs` frames a transaction, `xf_start` launches one byte, and the master answers with `xf_done` and the received byte. When the whole request has completed, or has stopped on an error, `done` pulses for one cycle and `err` carries the outcome.

Top module: `nor_pe_seq`

## Requirements
- R1: The command frame starts with the opcode, then sends the address bits 23:16, then 15:8, then 7:0 of the current offset. Program opcode is 0x02 and erase opcode is 0x20.
- R2: Every command chunk is preceded by a one-byte write-enable frame (0x06). `xf_cs` falls between all frames, and every `xf_start` occurs while `xf_cs` is high.
- R3: After each command, the block repeats a two-byte status frame (0x05 followed by a 0x00 dummy byte) until bit 0 of the returned byte is 0.
- R4: When `cfg_fsr_en` is 1, each poll also sends a two-byte flag frame (0x70 followed by 0x00). Ready then additionally requires bit 7 of the returned flag byte to be 1.
- R5: An erase whose offset or length is not a multiple of ERASE_SZ (4096) ends with `err`=1 and issues no SPI byte.
- R6: A program chunk is the smaller of the remaining length and the bytes left to the next PAGE_SZ (256) boundary. Its payload follows the address in order, and `dat_take` pulses once per payload byte.
- R7: When `cfg_max_wr` is nonzero, each program chunk is further limited to `cfg_max_wr` bytes.
- R8: When `cfg_bank_en` is 1 and offset>>24 differs from the cached bank (reset value 0), the block sends a frame of 0xC5 followed by the bank byte before the write-enable, and then updates the cache. Otherwise it sends no bank frame.
- R9: An erase issues one command per ERASE_SZ block, and the address advances by ERASE_SZ each time.
- R10: If the device is still busy once polling has run for PROG_TMO cycles (program) or ERASE_TMO cycles (erase), the request ends with `err`=2.
- R11: After reset, `busy`, `done`, `xf_cs` and `xf_start` are 0. `done` is a single-cycle pulse with `err`=0 on success, and a zero-length request completes with no SPI traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_off | input | ADDR_W | Start offset |
| req_len | input | LEN_W | Length in bytes |
| cfg_fsr_en | input | 1 | Also require the flag-status ready bit |
| cfg_bank_en | input | 1 | Enable bank-register maintenance |
| cfg_max_wr | input | LEN_W | Program chunk cap, 0 = none |
| dat_in | input | 8 | Current payload byte from host |
| dat_take | output | 1 | Payload byte consumed, host advances |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| err | output | 2 | 0 ok, 1 misaligned erase, 2 timeout |
| xf_cs | output | 1 | Chip-select frame, active high |
| xf_start | output | 1 | Launch one byte transfer |
| xf_tx | output | 8 | Byte to send |
| xf_done | input | 1 | Byte transfer finished |
| xf_rx | input | 8 | Byte received |

## Verification
The hardest case to reach from the ports is the poll loop in which the status register has already cleared but the flag register has not, or the reverse. A device model in the bench therefore holds the two busy indications for independently chosen poll counts per command. It reloads both counts whenever it sees a command opcode. Timeout expiry needs a device that never becomes ready. The bench keeps the status byte busy indefinitely and measures the cycles from the end of the command frame to `done`, separately for program and erase.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_PLAN, S_XFER, S_WAITB, S_GAP, S_EVAL, S_DONE} st_t;
  typedef enum logic [2:0] {K_BANK, K_WREN, K_CMD, K_SR, K_FSR} kind_t;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_RDSR   = 8'h05;
  localparam logic [7:0] OPC_RDFSR  = 8'h70;
  localparam logic [7:0] OPC_BANKWR = 8'hC5;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_ERASE  = 8'h20;
  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_ALIGN = 2'd1;
  localparam logic [1:0] ERR_TMO   = 2'd2;
endpackage

// File: rtl/nor_chunk_calc.sv
module nor_chunk_calc #(
  parameter int ADDR_W   = 26,
  parameter int LEN_W    = 16,
  parameter int PAGE_SZ  = 256,
  parameter int ERASE_SZ = 4096,
  parameter int BANK_SH  = 24
) (
  input  logic [ADDR_W-1:0] off,
  input  logic [LEN_W-1:0]  rem,
  input  logic              is_erase,
  input  logic [LEN_W-1:0]  max_wr,
  output logic [LEN_W-1:0]  chunk,
  output logic [7:0]        bank
);
  localparam int PG_W = $clog2(PAGE_SZ);

  logic [LEN_W-1:0] to_page;
  logic [LEN_W-1:0] lim;

  always_comb begin
    to_page = LEN_W'(PAGE_SZ) - LEN_W'(off[PG_W-1:0]);
    lim = (rem < to_page) ? rem : to_page;
    if (max_wr != '0 && max_wr < lim) lim = max_wr;
    chunk = is_erase ? LEN_W'(ERASE_SZ) : lim;
  end

  assign bank = 8'(off >> BANK_SH);
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (en && cnt < limit)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  // R10: once expired while running, stays expired until cleared
  a_r10_expiry_holds: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && expired) |=> expired);
endmodule

// File: rtl/nor_pe_seq.sv
module nor_pe_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int LEN_W     = 16,
  parameter int PAGE_SZ   = 256,
  parameter int ERASE_SZ  = 4096,
  parameter int BANK_SH   = 24,
  parameter int TMO_W     = 20,
  parameter int PROG_TMO  = 5000,
  parameter int ERASE_TMO = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_fsr_en,
  input  logic              cfg_bank_en,
  input  logic [LEN_W-1:0]  cfg_max_wr,
  input  logic [7:0]        dat_in,
  output logic              dat_take,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic              xf_cs,
  output logic              xf_start,
  output logic [7:0]        xf_tx,
  input  logic              xf_done,
  input  logic [7:0]        xf_rx
);
  localparam int EA_W = $clog2(ERASE_SZ);
  localparam int PG_W = $clog2(PAGE_SZ);

  st_t              state;
  kind_t            kind;
  logic             op_erase;
  logic [ADDR_W-1:0] cur_off;
  logic [LEN_W-1:0] rem, chunk_r, idx, flen;
  logic [7:0]       bank_r, bank_cur, sr_r, fsr_r, tx_b;
  logic             tmr_clr, tmr_en, tmr_exp, poll_ok, misaligned;
  logic [LEN_W-1:0] calc_chunk;
  logic [7:0]       calc_bank;

  nor_chunk_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SZ(PAGE_SZ),
                   .ERASE_SZ(ERASE_SZ), .BANK_SH(BANK_SH)) u_calc (
    .off(cur_off), .rem(rem), .is_erase(op_erase), .max_wr(cfg_max_wr),
    .chunk(calc_chunk), .bank(calc_bank));

  nor_poll_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en),
    .limit(op_erase ? TMO_W'(ERASE_TMO) : TMO_W'(PROG_TMO)),
    .expired(tmr_exp));

  assign misaligned = (|req_off[EA_W-1:0]) || (|req_len[EA_W-1:0]);
  assign poll_ok    = !sr_r[0] && (!cfg_fsr_en || fsr_r[7]);

  always_comb begin
    tx_b = 8'h00;
    case (kind)
      K_BANK: tx_b = (idx == '0) ? OPC_BANKWR : bank_r;
      K_WREN: tx_b = OPC_WREN;
      K_CMD: begin
        case (idx)
          LEN_W'(0): tx_b = op_erase ? OPC_ERASE : OPC_PROG;
          LEN_W'(1): tx_b = cur_off[23:16];
          LEN_W'(2): tx_b = cur_off[15:8];
          LEN_W'(3): tx_b = cur_off[7:0];
          default:   tx_b = dat_in;
        endcase
      end
      K_SR:    tx_b = (idx == '0) ? OPC_RDSR : 8'h00;
      K_FSR:   tx_b = (idx == '0) ? OPC_RDFSR : 8'h00;
      default: tx_b = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; kind <= K_WREN; op_erase <= 1'b0;
      cur_off <= '0; rem <= '0; chunk_r <= '0; idx <= '0; flen <= '0;
      bank_r <= '0; bank_cur <= '0; sr_r <= '0; fsr_r <= '0;
      tmr_clr <= 1'b0; tmr_en <= 1'b0;
      dat_take <= 1'b0; busy <= 1'b0; done <= 1'b0; err <= ERR_NONE;
      xf_cs <= 1'b0; xf_start <= 1'b0; xf_tx <= '0;
    end else begin
      done <= 1'b0; xf_start <= 1'b0; dat_take <= 1'b0; tmr_clr <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          busy <= 1'b1; op_erase <= req_erase; cur_off <= req_off;
          rem <= req_len; err <= ERR_NONE;
          if (req_erase && misaligned) begin
            err <= ERR_ALIGN; state <= S_DONE;
          end else if (req_len == '0) state <= S_DONE;
          else state <= S_PLAN;
        end
        S_PLAN: begin
          chunk_r <= calc_chunk; bank_r <= calc_bank; idx <= '0;
          if (cfg_bank_en && calc_bank != bank_cur) begin
            kind <= K_BANK; flen <= LEN_W'(2);
          end else begin
            kind <= K_WREN; flen <= LEN_W'(1);
          end
          state <= S_XFER;
        end
        S_XFER: begin
          xf_cs <= 1'b1; xf_start <= 1'b1; xf_tx <= tx_b;
          dat_take <= (kind == K_CMD) && (idx >= LEN_W'(4));
          state <= S_WAITB;
        end
        S_WAITB: if (xf_done) begin
          if (kind == K_SR  && idx == LEN_W'(1)) sr_r  <= xf_rx;
          if (kind == K_FSR && idx == LEN_W'(1)) fsr_r <= xf_rx;
          if (idx == flen - 1'b1) begin
            xf_cs <= 1'b0; state <= S_GAP;
          end else begin
            idx <= idx + 1'b1; state <= S_XFER;
          end
        end
        S_GAP: begin
          idx <= '0;
          case (kind)
            K_BANK: begin
              bank_cur <= bank_r; kind <= K_WREN; flen <= LEN_W'(1); state <= S_XFER;
            end
            K_WREN: begin
              kind <= K_CMD; state <= S_XFER;
              flen <= op_erase ? LEN_W'(4) : chunk_r + LEN_W'(4);
            end
            K_CMD: begin
              tmr_clr <= 1'b1; tmr_en <= 1'b1;
              kind <= K_SR; flen <= LEN_W'(2); state <= S_XFER;
            end
            K_SR: begin
              if (cfg_fsr_en) begin
                kind <= K_FSR; flen <= LEN_W'(2); state <= S_XFER;
              end else state <= S_EVAL;
            end
            default: state <= S_EVAL;
          endcase
        end
        S_EVAL: begin
          if (poll_ok) begin
            tmr_en <= 1'b0;
            cur_off <= cur_off + ADDR_W'(chunk_r);
            rem <= rem - chunk_r;
            state <= (rem == chunk_r) ? S_DONE : S_PLAN;
          end else if (tmr_exp) begin
            tmr_en <= 1'b0; err <= ERR_TMO; state <= S_DONE;
          end else begin
            kind <= K_SR; flen <= LEN_W'(2); state <= S_XFER;
          end
        end
        S_DONE: begin
          done <= 1'b1; busy <= 1'b0; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: bytes only launched inside a chip-select frame
  a_r2_start_in_frame: assert property (@(posedge clk) disable iff (rst)
    xf_start |-> xf_cs);
  // R5: misaligned erase goes straight to completion with no frame
  a_r5_align_reject: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && req_valid && req_erase && misaligned)
      |=> (state == S_DONE && err == ERR_ALIGN && !xf_cs));
  // R6: a program chunk never crosses a page and never exceeds the remainder
  a_r6_chunk_in_page: assert property (@(posedge clk) disable iff (rst)
    (state == S_PLAN && !op_erase) |->
      (calc_chunk != '0 && calc_chunk <= rem &&
       (LEN_W+1)'(cur_off[PG_W-1:0]) + (LEN_W+1)'(calc_chunk) <= (LEN_W+1)'(PAGE_SZ)));
  // R6: payload bytes are only taken in a program command frame
  a_r6_take_in_cmd: assert property (@(posedge clk) disable iff (rst)
    dat_take |-> (kind == K_CMD && !op_erase));
  // R7: nonzero cap bounds the chunk
  a_r7_cap: assert property (@(posedge clk) disable iff (rst)
    (state == S_PLAN && !op_erase && cfg_max_wr != '0) |-> calc_chunk <= cfg_max_wr);
  // R10: busy device with expired timer ends with timeout error
  a_r10_timeout_err: assert property (@(posedge clk) disable iff (rst)
    (state == S_EVAL && !poll_ok && tmr_exp) |=> (state == S_DONE && err == ERR_TMO));
  // R11: completion is a single-cycle pulse outside any frame
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_done_no_cs: assert property (@(posedge clk) disable iff (rst)
    done |-> !xf_cs);
endmodule

// File: tb/nor_pe_seq_bench.sv
module nor_pe_seq_bench;
  localparam int CLK_P = 10;
  localparam int AW = 26;
  localparam int LW = 16;
  localparam int PT = 300;
  localparam int ET = 900;
  localparam int ENDM = 256;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_erase = 0;
  logic [AW-1:0] req_off = '0;
  logic [LW-1:0] req_len = '0;
  logic cfg_fsr_en = 0, cfg_bank_en = 0;
  logic [LW-1:0] cfg_max_wr = '0;
  logic [7:0] dat_in;
  logic dat_take, busy, done, xf_cs, xf_start, xf_done = 0;
  logic [1:0] err;
  logic [7:0] xf_tx, xf_rx = '0;

  nor_pe_seq #(.ADDR_W(AW), .LEN_W(LW), .PROG_TMO(PT), .ERASE_TMO(ET)) u_nor_pe_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
    .req_off(req_off), .req_len(req_len), .cfg_fsr_en(cfg_fsr_en),
    .cfg_bank_en(cfg_bank_en), .cfg_max_wr(cfg_max_wr), .dat_in(dat_in),
    .dat_take(dat_take), .busy(busy), .done(done), .err(err), .xf_cs(xf_cs),
    .xf_start(xf_start), .xf_tx(xf_tx), .xf_done(xf_done), .xf_rx(xf_rx));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int exp_v[$];
  string exp_t[$];
  bit free_mode = 0;
  string unexp_tag = "R2";
  int sb_set = 0, fb_set = 0, sb_cnt = 0, fb_cnt = 0;
  logic [7:0] mem [0:511];
  int ptr = 0;
  int bcache = 0;
  int cyc = 0, t_cmd_end = 0;
  int pend = 0, fidx = 0;
  logic [7:0] fop = '0, rx_next = '0;
  logic prev_cs = 0;

  assign dat_in = mem[ptr];

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int v, string t);
    exp_v.push_back(v);
    exp_t.push_back(t);
  endtask

  // monitor and device model, all away from the active edge
  always @(negedge clk) begin
    xf_done = 0;
    if (dat_take) ptr++;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin xf_done = 1; xf_rx = rx_next; end
    end
    if (xf_start) begin
      if (fidx == 0) fop = xf_tx;
      rx_next = 8'h00;
      if (fidx == 0 && (xf_tx == 8'h02 || xf_tx == 8'h20)) begin
        sb_cnt = sb_set; fb_cnt = fb_set;
      end
      if (fidx == 1 && fop == 8'h05) begin
        rx_next = (sb_cnt > 0) ? 8'h03 : 8'h02;
        if (sb_cnt > 0) sb_cnt--;
      end
      if (fidx == 1 && fop == 8'h70) begin
        rx_next = (fb_cnt > 0) ? 8'h01 : 8'h81;
        if (fb_cnt > 0) fb_cnt--;
      end
      fidx++;
      pend = 2;
      if (!free_mode) begin
        if (exp_v.size() == 0) check(0, unexp_tag, "unexpected byte", int'(xf_tx), -1);
        else begin
          automatic int v = exp_v.pop_front();
          automatic string t = exp_t.pop_front();
          check(int'(xf_tx) == v, t, "tx byte", int'(xf_tx), v);
        end
      end
    end
    if (prev_cs && !xf_cs) begin
      if (fop == 8'h02 || fop == 8'h20) t_cmd_end = cyc;
      fidx = 0;
      if (!free_mode) begin
        if (exp_v.size() == 0) check(0, unexp_tag, "unexpected frame end", ENDM, -1);
        else begin
          automatic int v = exp_v.pop_front();
          automatic string t = exp_t.pop_front();
          check(v == ENDM, t, "frame end", ENDM, v);
        end
      end
    end
    prev_cs = xf_cs;
  end

  task automatic build(bit er, int off, int len, int sb, int fb, string ctag);
    int cur, rem, c, bk, n;
    cur = off; rem = len;
    while (rem > 0) begin
      if (er) c = 4096;
      else begin
        c = 256 - (cur % 256);
        if (rem < c) c = rem;
        if (cfg_max_wr != 0 && int'(cfg_max_wr) < c) c = int'(cfg_max_wr);
      end
      bk = cur >> 24;
      if (cfg_bank_en && bk != bcache) begin
        push(8'hC5, "R8"); push(bk, "R8"); push(ENDM, "R8"); bcache = bk;
      end
      push(8'h06, "R2"); push(ENDM, "R2");
      push(er ? 8'h20 : 8'h02, er ? "R9" : "R2");
      push((cur >> 16) & 255, "R1"); push((cur >> 8) & 255, "R1"); push(cur & 255, "R1");
      if (!er) for (int i = 0; i < c; i++) push(int'(mem[cur - off + i]), "R6");
      push(ENDM, ctag);
      n = sb;
      if (cfg_fsr_en && fb > n) n = fb;
      for (int p = 0; p <= n; p++) begin
        push(8'h05, "R3"); push(0, "R3"); push(ENDM, "R3");
        if (cfg_fsr_en) begin push(8'h70, "R4"); push(0, "R4"); push(ENDM, "R4"); end
      end
      cur += c; rem -= c;
    end
  endtask

  task automatic run_op(bit er, int off, int len, int sb, int fb, string ctag,
                        int exp_err, string etag);
    sb_set = sb; fb_set = fb; ptr = 0;
    if (exp_err == 0 && !free_mode) build(er, off, len, sb, fb, ctag);
    @(negedge clk);
    req_valid = 1; req_erase = er; req_off = AW'(off); req_len = LW'(len);
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    check(err == 2'(exp_err), etag, "err code", int'(err), exp_err);
    check(exp_v.size() == 0, ctag, "items left", exp_v.size(), 0);
    exp_v.delete(); exp_t.delete();
    @(negedge clk);
    check(!done && !busy, "R11", "done pulse ends", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int el;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !xf_cs && !xf_start, "R11", "reset outputs",
          {busy, done, xf_cs, xf_start}, 0);

    // R1 R2 R3: simple program with two busy polls
    run_op(0, 32'h000010, 8, 2, 0, "R2", 0, "R3");
    // R6: crossing a page boundary -> 16 then 24
    run_op(0, 32'h0001F0, 40, 1, 0, "R6", 0, "R6");
    // R7: cap of 8 -> 8, 8, 4
    cfg_max_wr = 8;
    run_op(0, 32'h000300, 20, 0, 0, "R7", 0, "R7");
    cfg_max_wr = 0;
    // R4: flag status lags status, then status lags flag
    cfg_fsr_en = 1;
    run_op(0, 32'h000040, 3, 0, 2, "R4", 0, "R4");
    run_op(0, 32'h000080, 2, 3, 1, "R4", 0, "R4");
    cfg_fsr_en = 0;
    // R8: bank change, same bank, back to bank 0
    cfg_bank_en = 1;
    run_op(0, 32'h1000000, 4, 0, 0, "R8", 0, "R8");
    run_op(0, 32'h1000100, 4, 0, 0, "R8", 0, "R8");
    run_op(0, 32'h0000020, 4, 1, 0, "R8", 0, "R8");
    cfg_bank_en = 0;
    // R9: erase two blocks
    run_op(1, 32'h002000, 8192, 1, 0, "R9", 0, "R9");
    // R5: misaligned offset, misaligned length
    unexp_tag = "R5";
    run_op(1, 32'h002100, 4096, 0, 0, "R5", 1, "R5");
    run_op(1, 32'h003000, 4000, 0, 0, "R5", 1, "R5");
    // R11: zero-length program
    unexp_tag = "R11";
    run_op(0, 32'h000000, 0, 0, 0, "R11", 0, "R11");
    unexp_tag = "R2";
    // R10: program and erase timeouts
    free_mode = 1;
    run_op(0, 32'h000000, 4, 1000000, 0, "R10", 2, "R10");
    el = cyc - t_cmd_end;
    check(el >= PT && el <= PT + 60, "R10", "program timeout cycles", el, PT);
    run_op(1, 32'h000000, 4096, 1000000, 0, "R10", 2, "R10");
    el = cyc - t_cmd_end;
    check(el >= ET && el <= ET + 60, "R10", "erase timeout cycles", el, ET);
    free_mode = 0;
    // recovery after timeout
    run_op(0, 32'h000100, 2, 0, 0, "R2", 0, "R11");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule